// File: doc/BRIEF.md
# LED Column Display Stream Driver

This block feeds a column-scanned LED display one column at a time. A host fills a small column buffer through a word-wide write port. Each of the 28 words in that buffer holds eight 2-bit pixels. The host then requests a column. The block answers with a one-cycle line strobe, followed by exactly 28 data beats on a 16-bit bus. Each beat is latched by the display on the rising edge of a data shift clock, and the block sets up and holds the data around that edge.

The display's active-high select line also acts as its reset. The block drives this line from a host enable, delayed by one register stage. While the line is low, no strobe and no shift clock reach the display. If the enable drops in the middle of a column, the column is abandoned and no completion pulse is given. Several columns may be sent one after another while the select stays high.

Top module: `ledcol_stream_drv`

## Requirements
- R1: While `rst` is high, at the next clock edge `disp_sel`, `disp_dclk`, `disp_lstrobe`, `busy` and `col_done` are all low and `disp_data` is zero.
- R2: `disp_sel` equals the value `panel_enable` had one cycle earlier. When `panel_enable` is sampled low, the next cycle shows `busy`, `disp_dclk` and `disp_lstrobe` low, and an abandoned column produces no `col_done`.
- R3: A `start_col` pulse is accepted only when `busy` is low and both `disp_sel` and `panel_enable` are high. A `start_col` pulse in any other condition produces no strobe and no shift clock.
- R4: `disp_lstrobe` is high for exactly one cycle, the cycle after an accepted start, and it is never high together with `disp_dclk`.
- R5: Each column carries exactly 28 `disp_dclk` pulses. Each pulse is high for one cycle and is followed by one low cycle. The first pulse comes two cycles after the strobe cycle.
- R6: Beat k, for k = 0 to 27 and sent in rising order, places buffer word k on `disp_data`. Pixel 8k+n of the column sits on bits [2n+1:2n] of that beat.
- R7: `disp_data` carries the beat's word during the cycle before the rising edge of `disp_dclk` and during the high cycle. Outside a beat it is zero.
- R8: `col_done` is high for one cycle, the cycle right after the 28th shift-clock high cycle. `busy` is low in the cycle after that.
- R9: A write with `wr_en` high while `busy` is high leaves the buffer unchanged.
- R10: `busy` is high from the strobe cycle through the `col_done` cycle inclusive, which is 58 cycles per column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| panel_enable | input | 1 | Host request to select the display |
| wr_en | input | 1 | Column buffer write strobe |
| wr_addr | input | 5 | Column buffer word index (0 to 27) |
| wr_data | input | 16 | Eight packed 2-bit pixels |
| start_col | input | 1 | Request to send one column |
| busy | output | 1 | Column transfer in progress |
| col_done | output | 1 | One-cycle completion pulse |
| disp_sel | output | 1 | Display select, active high, doubles as display reset |
| disp_lstrobe | output | 1 | Column-start strobe |
| disp_dclk | output | 1 | Data shift clock |
| disp_data | output | 16 | Parallel pixel data bus |

## Verification
The bench fills the buffer with random words and checks every cycle of each column against a cycle map worked out from the requirements. A design that miscounted beats would show a 27th or 29th clock pulse, or a `col_done` pulse in the wrong cycle. A design that mis-indexed the buffer would show a word shifted by one beat. The bench also writes to the buffer and raises `start_col` in the middle of a transfer. A design that did not gate these would corrupt the next column or fire a second strobe. Finally, the bench drops `panel_enable` partway through a column, and a design that did not abort would keep clocking into a deselected display or report a false completion.

// File: rtl/ledcol_pkg.sv
package ledcol_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STRB  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_t;

endpackage

// File: rtl/ledcol_colbuf.sv
module ledcol_colbuf #(
   parameter int BUS_W     = 16,
   parameter int DEPTH     = 28,
   parameter int AW        = 5,
   parameter bit RESET_BUF = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [BUS_W-1:0] rd_data
);

   logic [BUS_W-1:0] mem_q [DEPTH];

   generate
      if (RESET_BUF) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
               mem_q[wr_addr] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_addr) < DEPTH)) begin
               mem_q[wr_addr] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;

endmodule

// File: rtl/ledcol_seq.sv
module ledcol_seq
   import ledcol_pkg::*;
#(
   parameter int BEATS = 28,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          panel_enable,
   input  logic          start_col,
   output seq_state_t    state,
   output logic [CW-1:0] beat_idx,
   output logic          phase_hi,
   output logic          sel_q
);

   seq_state_t    state_q;
   logic [CW-1:0] beat_q;
   logic          phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q   <= 1'b0;
         state_q <= ST_IDLE;
         beat_q  <= '0;
         phase_q <= 1'b0;
      end else begin
         sel_q <= panel_enable;
         if (!panel_enable) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            phase_q <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (start_col && sel_q) state_q <= ST_STRB;
               end
               ST_STRB: begin
                  state_q <= ST_SHIFT;
                  beat_q  <= '0;
                  phase_q <= 1'b0;
               end
               ST_SHIFT: begin
                  phase_q <= ~phase_q;
                  if (phase_q) begin
                     if (beat_q == CW'(BEATS - 1)) begin
                        state_q <= ST_DONE;
                        beat_q  <= '0;
                     end else begin
                        beat_q <= beat_q + 1'b1;
                     end
                  end
               end
               ST_DONE: state_q <= ST_IDLE;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign state    = state_q;
   assign beat_idx = beat_q;
   assign phase_hi = phase_q;

endmodule

// File: rtl/ledcol_beat_drive.sv
module ledcol_beat_drive
   import ledcol_pkg::*;
#(
   parameter int BUS_W = 16,
   parameter int PIX_W = 2
) (
   input  seq_state_t       state,
   input  logic             phase_hi,
   input  logic [BUS_W-1:0] word,
   output logic [BUS_W-1:0] disp_data,
   output logic             disp_dclk,
   output logic             disp_lstrobe,
   output logic             col_done
);

   localparam int LANES = BUS_W / PIX_W;

   logic shifting;
   assign shifting = (state == ST_SHIFT);

   // pixel n of the beat drives lanes [PIX_W*n +: PIX_W]
   generate
      for (genvar n = 0; n < LANES; n++) begin : g_lane
         assign disp_data[n*PIX_W +: PIX_W] = shifting ? word[n*PIX_W +: PIX_W] : '0;
      end
   endgenerate

   assign disp_dclk    = shifting && phase_hi;
   assign disp_lstrobe = (state == ST_STRB);
   assign col_done     = (state == ST_DONE);

endmodule

// File: rtl/ledcol_stream_drv.sv
module ledcol_stream_drv
   import ledcol_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int PIX_W     = 2,
   parameter int BEATS     = 28,
   parameter bit RESET_BUF = 1'b0,
   localparam int AW       = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             panel_enable,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             start_col,
   output logic             busy,
   output logic             col_done,
   output logic             disp_sel,
   output logic             disp_lstrobe,
   output logic             disp_dclk,
   output logic [BUS_W-1:0] disp_data
);

   generate
      if ((BUS_W % PIX_W) != 0) begin : g_bad_width
         $error("bus width must be a whole number of pixels");
      end
      if (BEATS < 1) begin : g_bad_beats
         $error("a column needs at least one beat");
      end
   endgenerate

   seq_state_t       state;
   logic [AW-1:0]    beat_idx;
   logic             phase_hi;
   logic [BUS_W-1:0] cur_word;

   ledcol_colbuf #(
      .BUS_W(BUS_W), .DEPTH(BEATS), .AW(AW), .RESET_BUF(RESET_BUF)
   ) u_buf (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en && !busy),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(beat_idx),
      .rd_data(cur_word)
   );

   ledcol_seq #(.BEATS(BEATS), .CW(AW)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .panel_enable(panel_enable),
      .start_col   (start_col),
      .state       (state),
      .beat_idx    (beat_idx),
      .phase_hi    (phase_hi),
      .sel_q       (disp_sel)
   );

   ledcol_beat_drive #(.BUS_W(BUS_W), .PIX_W(PIX_W)) u_drv (
      .state       (state),
      .phase_hi    (phase_hi),
      .word        (cur_word),
      .disp_data   (disp_data),
      .disp_dclk   (disp_dclk),
      .disp_lstrobe(disp_lstrobe),
      .col_done    (col_done)
   );

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ledcol_stream_chk.sv
module ledcol_stream_chk #(
   parameter int BUS_W = 16,
   parameter int AW    = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             panel_enable,
   input logic             wr_en,
   input logic [AW-1:0]    wr_addr,
   input logic [BUS_W-1:0] wr_data,
   input logic             start_col,
   input logic             busy,
   input logic             col_done,
   input logic             disp_sel,
   input logic             disp_lstrobe,
   input logic             disp_dclk,
   input logic [BUS_W-1:0] disp_data
);

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!disp_sel && !disp_dclk && !disp_lstrobe && !busy && !col_done && disp_data == '0));

   a_r2_sel_follows: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (disp_sel == $past(panel_enable)));

   a_r2_abort: assert property (@(posedge clk) disable iff (rst)
      !panel_enable |=> (!busy && !disp_dclk && !disp_lstrobe && !col_done));

   a_r3_accept: assert property (@(posedge clk) disable iff (rst)
      (start_col && !busy && disp_sel && panel_enable) |=> disp_lstrobe);

   a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
      disp_lstrobe |=> !disp_lstrobe);

   a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(disp_lstrobe && disp_dclk));

   a_r5_dclk_single: assert property (@(posedge clk) disable iff (rst)
      disp_dclk |=> !disp_dclk);

   a_r7_setup_hold: assert property (@(posedge clk) disable iff (rst)
      $rose(disp_dclk) |-> $stable(disp_data));

   a_r8_done_after_clk: assert property (@(posedge clk) disable iff (rst)
      col_done |-> $past(disp_dclk));

   a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
      col_done |=> !busy);

endmodule

bind ledcol_stream_drv ledcol_stream_chk #(.BUS_W(BUS_W), .AW(AW)) u_chk (.*);

// File: tb/ledcol_stream_drv_tb_top.sv
module ledcol_stream_drv_tb_top;

   localparam int BEATS = 28;

   logic        clk = 1'b0;
   logic        rst;
   logic        panel_enable;
   logic        wr_en;
   logic [4:0]  wr_addr;
   logic [15:0] wr_data;
   logic        start_col;
   logic        busy, col_done, disp_sel, disp_lstrobe, disp_dclk;
   logic [15:0] disp_data;

   logic [15:0] model [BEATS];
   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ledcol_stream_drv dut_i (
      .clk(clk), .rst(rst), .panel_enable(panel_enable), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .start_col(start_col),
      .busy(busy), .col_done(col_done), .disp_sel(disp_sel),
      .disp_lstrobe(disp_lstrobe), .disp_dclk(disp_dclk), .disp_data(disp_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [15:0] pack_word(input int k);
      logic [15:0] w;
      for (int n = 0; n < 8; n++) begin
         int p = 8 * k + n;
         w[2*n +: 2] = 2'((p ^ (p >> 3)) & 3);
      end
      return w;
   endfunction

   task automatic load_buf(input bit rnd);
      for (int k = 0; k < BEATS; k++) begin
         wr_en   = 1'b1;
         wr_addr = 5'(k);
         wr_data = rnd ? 16'($urandom) : pack_word(k);
         model[k] = wr_data;
         tick();
      end
      wr_en = 1'b0;
   endtask

   // called at a negedge with the block idle and selected
   task automatic run_col(input bit poke);
      start_col = 1'b1;
      tick();
      start_col = 1'b0;
      for (int idx = 0; idx < 60; idx++) begin
         bit          e_str  = (idx == 0);
         bit          e_clk  = (idx >= 2) && (idx <= 56) && (idx % 2 == 0);
         bit          e_done = (idx == 57);
         bit          e_busy = (idx <= 57);
         logic [15:0] e_dat  = (idx >= 1 && idx <= 56) ? model[(idx - 1) / 2] : 16'h0;
         chk(disp_lstrobe == e_str, "R4", "strobe", 32'(disp_lstrobe), 32'(e_str));
         chk(disp_dclk == e_clk, "R5", "dclk", 32'(disp_dclk), 32'(e_clk));
         chk(disp_data == e_dat, e_clk ? "R6" : "R7", "data", 32'(disp_data), 32'(e_dat));
         chk(col_done == e_done, "R8", "done", 32'(col_done), 32'(e_done));
         chk(busy == e_busy, "R10", "busy", 32'(busy), 32'(e_busy));
         if (idx == 8)
            chk(disp_data == model[3], "R9", "beat3 word", 32'(disp_data), 32'(model[3]));
         wr_en     = poke && (idx == 10);
         wr_addr   = 5'd3;
         wr_data   = ~model[3];
         start_col = (idx == 20);
         tick();
      end
      wr_en     = 1'b0;
      start_col = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int dones;
      void'($urandom(32'h1ED5_C011));
      rst = 1'b1; panel_enable = 1'b0; wr_en = 1'b0; wr_addr = '0;
      wr_data = '0; start_col = 1'b0;
      tick(); tick();
      // R1 reset state
      chk(!disp_sel && !disp_dclk && !disp_lstrobe && !busy && !col_done,
          "R1", "controls", {27'b0, disp_sel, disp_dclk, disp_lstrobe, busy, col_done}, 32'h0);
      chk(disp_data == 16'h0, "R1", "data", 32'(disp_data), 32'h0);
      rst = 1'b0;
      tick();

      load_buf(1'b0);

      // R3: start while deselected is ignored
      start_col = 1'b1;
      tick();
      start_col = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(!busy && !disp_lstrobe && !disp_dclk, "R3", "start unselected",
             {29'b0, busy, disp_lstrobe, disp_dclk}, 32'h0);
         tick();
      end

      // R2: select follows enable
      panel_enable = 1'b1;
      chk(disp_sel == 1'b0, "R2", "sel before", 32'(disp_sel), 32'h0);
      tick();
      chk(disp_sel == 1'b1, "R2", "sel after", 32'(disp_sel), 32'h1);

      // directed pixel packing column, with mid-transfer write and start
      run_col(1'b1);
      run_col(1'b0);

      // back-to-back random columns
      for (int c = 0; c < 4; c++) begin
         load_buf(1'b1);
         run_col(c[0]);
      end

      // R2: abort in the middle of a column
      start_col = 1'b1;
      tick();
      start_col = 1'b0;
      repeat (12) tick();
      panel_enable = 1'b0;
      tick();
      chk(!busy && !disp_dclk && !disp_lstrobe && !disp_sel, "R2", "abort",
          {28'b0, busy, disp_dclk, disp_lstrobe, disp_sel}, 32'h0);
      dones = 0;
      for (int i = 0; i < 60; i++) begin
         if (col_done || disp_dclk) dones++;
         tick();
      end
      chk(dones == 0, "R2", "activity after abort", 32'(dones), 32'h0);

      // recovery
      panel_enable = 1'b1;
      tick(); tick();
      load_buf(1'b1);
      run_col(1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule